// File: doc/BRIEF.md
# Binary Dot-Product Coprocessor

This block stores a table of binary feature rows on chip and returns the dot product of any two of them. Because every feature is a single bit, the dot product of two rows equals the number of positions where both rows hold a one. The block computes this as a bitwise AND followed by a population count. A host fills the table once and then asks for many products by index. This fits training loops that compare the same samples again and again.

The host works through a small set of write strobes:

- a 16-bit control word;
- two index registers;
- a row-data port.

Two read-only words return the status and the last count. One control bit sets the mode:

- **Load mode:** index A addresses the table and row words are stored there.
- **Compute mode:** a start request reads the two indexed rows and delivers the count a fixed three clock edges later, whatever the row width.

Top module: `bdp_coproc`

## Requirements
- R1: After `rstN` is low for a clock edge, `ctrlReg` reads 0, `resultReg` reads 0, the block is in load mode, and both index registers hold 0.
- R2: In load mode (`ctrlReg` bit 0 = 0), a `rowWr` pulse stores `rowData` into the row addressed by the current index A.
- R3: In load mode, a write to index B is ignored, so B keeps its previous value.
- R4: In compute mode (`ctrlReg` bit 0 = 1), a `rowWr` pulse leaves the table unchanged.
- R5: A computation returns the count of ones in (row[A] AND row[B]), from 0 up to the row width. This holds for A = B, for an all-zero row and for an all-one row.
- R6: The control layout is:
  - bit 0: mode;
  - bit 1: soft reset;
  - bit 2: finish, read-only;
  - bit 3: start.

  A start is a control write with bit 3 = 1 and bit 0 = 1. When the start is sampled at edge k, finish stays 0 after edges k and k+1. After edge k+2, finish reads 1 and `resultReg` holds the new count.
- R7: Finish stays 1 until either an accepted start or an accepted index write clears it, one edge after the write.
- R8: Some start requests are ignored. They change neither the result nor finish:
  - a start in a control write whose bit 0 is 0;
  - a start that arrives while a computation is still in flight.
- R9: A control write with bit 1 = 1 does the following:
  - clears mode, finish, both index registers and the result;
  - cancels any computation in flight;
  - overrides every other bit of the same write;
  - always reads back as 0.

  The table contents survive it.
- R10: If an accepted index write lands on the same edge that completes a computation, the result still updates but finish stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| ctrlWr | input | 1 | Control word write strobe |
| ctrlData | input | 16 | Control word written (bit0 mode, bit1 soft reset, bit3 start) |
| idxAWr | input | 1 | Index A write strobe |
| idxBWr | input | 1 | Index B write strobe (compute mode only) |
| idxData | input | IDX_W | Index value for either index register |
| rowWr | input | 1 | Row write strobe (load mode only) |
| rowData | input | ROW_BITS | Row word stored at index A |
| ctrlReg | output | 16 | Status: bit0 mode, bit2 finish, others 0 |
| resultReg | output | CNT_W | Last dot-product count |

## Verification
Two events can meet on one edge: the completion of a computation, which sets finish, and a host write to an index register, which clears it. The bench triggers this by pulsing the index A write exactly two edges after an accepted start. It then expects the result to carry the count for the old index pair while finish reads 0. A second overlap is also tested: a start that arrives while the pipeline is still busy must be dropped. For that case the bench checks that the reported count belongs to the first index pair and that nothing later overwrites it.

// File: rtl/bdp_pkg.sv
package bdp_pkg;

  localparam int CTL_W     = 16;
  localparam int CTL_PHASE = 0;
  localparam int CTL_RST   = 1;
  localparam int CTL_FIN   = 2;
  localparam int CTL_GO    = 3;

  localparam int POP_CHUNK = 8;

  typedef struct packed {
    logic clearAll;
    logic memWr;
    logic fetch;
    logic compute;
  } dpStrobes_t;

endpackage

// File: rtl/bdp_ctrl.sv
module bdp_ctrl
  import bdp_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ctrlWr,
  input  logic [CTL_W-1:0] ctrlData,
  input  logic             idxAWr,
  input  logic             idxBWr,
  input  logic [IDX_W-1:0] idxData,
  input  logic             rowWr,
  output dpStrobes_t       strobes,
  output logic [IDX_W-1:0] wrAddr,
  output logic [IDX_W-1:0] rdAddrA,
  output logic [IDX_W-1:0] rdAddrB,
  output logic             phase,
  output logic             finish
);

  logic             phaseQ;
  logic             finishQ;
  logic             stage1Q;
  logic             stage2Q;
  logic [IDX_W-1:0] idxAQ;
  logic [IDX_W-1:0] idxBQ;
  logic [IDX_W-1:0] capAQ;
  logic [IDX_W-1:0] capBQ;

  logic softRst;
  logic busy;
  logic goAccept;
  logic idxBTake;
  logic idxTouch;

  always_comb begin
    softRst  = ctrlWr && ctrlData[CTL_RST];
    busy     = stage1Q || stage2Q;
    goAccept = ctrlWr && !softRst && ctrlData[CTL_GO] &&
               ctrlData[CTL_PHASE] && !busy;
    idxBTake = idxBWr && phaseQ;
    idxTouch = idxAWr || idxBTake;
  end

  always_ff @(posedge clk) begin
    if (!rstN || softRst) begin
      phaseQ  <= 1'b0;
      finishQ <= 1'b0;
      stage1Q <= 1'b0;
      stage2Q <= 1'b0;
      idxAQ   <= '0;
      idxBQ   <= '0;
      capAQ   <= '0;
      capBQ   <= '0;
    end else begin
      if (ctrlWr) phaseQ <= ctrlData[CTL_PHASE];
      if (idxAWr) idxAQ <= idxData;
      if (idxBTake) idxBQ <= idxData;
      stage1Q <= goAccept;
      stage2Q <= stage1Q;
      if (goAccept) begin
        capAQ <= idxAQ;
        capBQ <= idxBQ;
      end
      if (goAccept || idxTouch) finishQ <= 1'b0;
      else if (stage2Q)         finishQ <= 1'b1;
    end
  end

  always_comb begin
    strobes.clearAll = softRst;
    strobes.memWr    = rowWr && !phaseQ;
    strobes.fetch    = stage1Q;
    strobes.compute  = stage2Q;
  end

  assign wrAddr  = idxAQ;
  assign rdAddrA = capAQ;
  assign rdAddrB = capBQ;
  assign phase   = phaseQ;
  assign finish  = finishQ;

endmodule

// File: rtl/bdp_datapath.sv
module bdp_datapath
  import bdp_pkg::*;
#(
  parameter int ROW_BITS = 128,
  parameter int DEPTH    = 256,
  parameter int IDX_W    = 8,
  parameter int CNT_W    = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobes_t          strobes,
  input  logic [IDX_W-1:0]    wrAddr,
  input  logic [IDX_W-1:0]    rdAddrA,
  input  logic [IDX_W-1:0]    rdAddrB,
  input  logic [ROW_BITS-1:0] rowData,
  output logic [CNT_W-1:0]    result
);

  localparam int NCHUNK = ROW_BITS / POP_CHUNK;
  localparam int PART_W = $clog2(POP_CHUNK + 1);

  logic [ROW_BITS-1:0]     rowMem [DEPTH];
  logic [ROW_BITS-1:0]     rowAQ;
  logic [ROW_BITS-1:0]     rowBQ;
  logic [ROW_BITS-1:0]     andVec;
  logic [NCHUNK*PART_W-1:0] partFlat;
  logic [CNT_W-1:0]        total;
  logic [CNT_W-1:0]        resultQ;

  function automatic logic [PART_W-1:0] chunkPop(input logic [POP_CHUNK-1:0] v);
    logic [PART_W-1:0] c;
    c = '0;
    for (int k = 0; k < POP_CHUNK; k++) c = c + PART_W'(v[k]);
    return c;
  endfunction

  always_ff @(posedge clk) begin
    if (strobes.memWr) rowMem[wrAddr] <= rowData;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobes.clearAll) begin
      rowAQ <= '0;
      rowBQ <= '0;
    end else if (strobes.fetch) begin
      rowAQ <= rowMem[rdAddrA];
      rowBQ <= rowMem[rdAddrB];
    end
  end

  assign andVec = rowAQ & rowBQ;

  generate
    for (genvar g = 0; g < NCHUNK; g++) begin : g_chunk
      assign partFlat[g*PART_W +: PART_W] = chunkPop(andVec[g*POP_CHUNK +: POP_CHUNK]);
    end
  endgenerate

  always_comb begin
    total = '0;
    for (int c = 0; c < NCHUNK; c++) total = total + CNT_W'(partFlat[c*PART_W +: PART_W]);
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobes.clearAll) resultQ <= '0;
    else if (strobes.compute)      resultQ <= total;
  end

  assign result = resultQ;

endmodule

// File: rtl/bdp_coproc.sv
module bdp_coproc
  import bdp_pkg::*;
#(
  parameter int ROW_BITS = 128,
  parameter int DEPTH    = 256,
  localparam int IDX_W   = $clog2(DEPTH),
  localparam int CNT_W   = $clog2(ROW_BITS + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                ctrlWr,
  input  logic [15:0]         ctrlData,
  input  logic                idxAWr,
  input  logic                idxBWr,
  input  logic [IDX_W-1:0]    idxData,
  input  logic                rowWr,
  input  logic [ROW_BITS-1:0] rowData,
  output logic [15:0]         ctrlReg,
  output logic [CNT_W-1:0]    resultReg
);

  dpStrobes_t       strobes;
  logic [IDX_W-1:0] wrAddr;
  logic [IDX_W-1:0] rdAddrA;
  logic [IDX_W-1:0] rdAddrB;
  logic             phase;
  logic             finish;

  bdp_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .ctrlWr  (ctrlWr),
    .ctrlData(ctrlData),
    .idxAWr  (idxAWr),
    .idxBWr  (idxBWr),
    .idxData (idxData),
    .rowWr   (rowWr),
    .strobes (strobes),
    .wrAddr  (wrAddr),
    .rdAddrA (rdAddrA),
    .rdAddrB (rdAddrB),
    .phase   (phase),
    .finish  (finish)
  );

  bdp_datapath #(
    .ROW_BITS(ROW_BITS),
    .DEPTH   (DEPTH),
    .IDX_W   (IDX_W),
    .CNT_W   (CNT_W)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .wrAddr (wrAddr),
    .rdAddrA(rdAddrA),
    .rdAddrB(rdAddrB),
    .rowData(rowData),
    .result (resultReg)
  );

  always_comb begin
    ctrlReg            = '0;
    ctrlReg[CTL_PHASE] = phase;
    ctrlReg[CTL_FIN]   = finish;
  end

endmodule

// File: rtl/bdp_coproc_chk.sv
module bdp_coproc_chk
  import bdp_pkg::*;
#(
  parameter int ROW_BITS = 128,
  parameter int CNT_W    = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             ctrlWr,
  input logic [15:0]      ctrlData,
  input logic             idxAWr,
  input logic             idxBWr,
  input logic [15:0]      ctrlReg,
  input logic [CNT_W-1:0] resultReg
);

  logic goWrite;
  logic rstWrite;
  assign goWrite  = ctrlWr && ctrlData[CTL_GO] && ctrlData[CTL_PHASE] && !ctrlData[CTL_RST];
  assign rstWrite = ctrlWr && ctrlData[CTL_RST];

  AST_SOFT_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    rstWrite |=> (ctrlReg == 16'h0 && resultReg == '0)); // R9

  AST_RESULT_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    resultReg <= CNT_W'(ROW_BITS)); // R5

  AST_INDEX_CLEARS_FINISH: assert property (@(posedge clk) disable iff (!rstN)
    (idxAWr && !rstWrite) |=> !ctrlReg[CTL_FIN]); // R7

  AST_RESULT_AFTER_START: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(resultReg) && !$past(rstWrite)) |-> $past(goWrite, 3)); // R6

  AST_FINISH_AFTER_START: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctrlReg[CTL_FIN]) |-> $past(goWrite, 3)); // R6

endmodule

bind bdp_coproc bdp_coproc_chk #(.ROW_BITS(ROW_BITS), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .ctrlWr   (ctrlWr),
  .ctrlData (ctrlData),
  .idxAWr   (idxAWr),
  .idxBWr   (idxBWr),
  .ctrlReg  (ctrlReg),
  .resultReg(resultReg)
);

// File: tb/sim_bdp_coproc.sv
module sim_bdp_coproc;

  localparam int ROW_BITS = 128;
  localparam int DEPTH    = 32;
  localparam int IDX_W    = $clog2(DEPTH);
  localparam int CNT_W    = $clog2(ROW_BITS + 1);

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic                ctrlWr = 1'b0;
  logic [15:0]         ctrlData = '0;
  logic                idxAWr = 1'b0;
  logic                idxBWr = 1'b0;
  logic [IDX_W-1:0]    idxData = '0;
  logic                rowWr = 1'b0;
  logic [ROW_BITS-1:0] rowData = '0;
  logic [15:0]         ctrlReg;
  logic [CNT_W-1:0]    resultReg;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;
  logic [ROW_BITS-1:0] model [DEPTH];
  int expQ[$];
  logic prevFin = 1'b0;

  always #5 clk = ~clk;

  bdp_coproc #(.ROW_BITS(ROW_BITS), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .ctrlData(ctrlData),
    .idxAWr(idxAWr), .idxBWr(idxBWr), .idxData(idxData),
    .rowWr(rowWr), .rowData(rowData), .ctrlReg(ctrlReg), .resultReg(resultReg)
  );

  task automatic check(input string req, input bit ok, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int popRef(input int a, input int b);
    return $countones(model[a] & model[b]);
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wrCtrl(input logic [15:0] v);
    ctrlWr = 1'b1; ctrlData = v; tick(); ctrlWr = 1'b0;
  endtask

  task automatic wrIdxA(input int v);
    idxAWr = 1'b1; idxData = IDX_W'(v); tick(); idxAWr = 1'b0;
  endtask

  task automatic wrIdxB(input int v);
    idxBWr = 1'b1; idxData = IDX_W'(v); tick(); idxBWr = 1'b0;
  endtask

  task automatic wrRow(input logic [ROW_BITS-1:0] d);
    rowWr = 1'b1; rowData = d; tick(); rowWr = 1'b0;
  endtask

  // start request with latency checks; monitor compares the count
  task automatic goStart(input int expVal);
    expQ.push_back(expVal);
    ctrlWr = 1'b1; ctrlData = 16'h0009;
    tick(); ctrlWr = 1'b0;
    check("R7 finish cleared by start", ctrlReg[2] == 1'b0, ctrlReg[2], 0);
    tick();
    check("R6 finish low one edge later", ctrlReg[2] == 1'b0, ctrlReg[2], 0);
    tick();
    check("R6 finish high at third edge", ctrlReg[2] == 1'b1, ctrlReg[2], 1);
  endtask

  task automatic dotReq(input int a, input int b);
    wrIdxA(a); wrIdxB(b); goStart(popRef(a, b));
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN) begin
      if (ctrlReg[2] && !prevFin) begin
        if (expQ.size() == 0) check("R6 unexpected finish", 1'b0, 1, 0);
        else begin
          int e;
          e = expQ.pop_front();
          check("R5 dot product count", int'(resultReg) == e, resultReg, e);
        end
      end
      prevFin = ctrlReg[2];
    end
  end

  task automatic finishRun();
    check("R5 scoreboard drained", expQ.size() == 0, expQ.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      check("watchdog expired", 1'b0, 1, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] r0;
    logic [CNT_W-1:0] held;
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    check("R1 ctrl after reset", ctrlReg == 16'h0, ctrlReg, 0);
    check("R1 result after reset", resultReg == '0, resultReg, 0);

    // R2: load the table in load mode
    for (int i = 0; i < DEPTH; i++) begin
      if (i == 0)      model[i] = '0;
      else if (i == 1) model[i] = '1;
      else             model[i] = {$urandom, $urandom, $urandom, $urandom};
      wrIdxA(i); wrRow(model[i]);
    end
    model[7][0] = 1'b1;  // row 7 guaranteed non-zero
    wrIdxA(7); wrRow(model[7]);

    // R3: B write in load mode ignored, B stays 0
    wrIdxB(7);
    wrCtrl(16'h0001);
    check("R6 mode bit reads 1", ctrlReg[0] == 1'b1, ctrlReg[0], 1);
    wrIdxA(1);
    goStart(popRef(1, 0));  // R3 expects row1&row0, not row1&row7

    // R5 corner rows and A = B
    dotReq(1, 1);
    dotReq(0, 1);
    dotReq(0, 0);
    dotReq(5, 5);
    dotReq(1, 9);
    // R2 random pairs
    for (int n = 0; n < 40; n++) begin
      int a, b;
      a = $urandom_range(DEPTH - 1);
      b = (n % 5 == 0) ? a : $urandom_range(DEPTH - 1);
      dotReq(a, b);
    end

    // R4: row write in compute mode ignored
    wrIdxA(5);
    wrRow(~model[5]);
    dotReq(5, 5);  // R4 expects original row 5

    // R7: finish holds, then index write clears it
    repeat (4) tick();
    check("R7 finish holds while idle", ctrlReg[2] == 1'b1, ctrlReg[2], 1);
    wrIdxA(3);
    check("R7 index write clears finish", ctrlReg[2] == 1'b0, ctrlReg[2], 0);
    wrIdxB(4);
    goStart(popRef(3, 4));
    goStart(popRef(3, 4));  // start directly with finish high

    // R8: start while busy is ignored
    wrIdxA(2); wrIdxB(3);
    expQ.push_back(popRef(2, 3));
    ctrlWr = 1'b1; ctrlData = 16'h0009; tick();
    ctrlWr = 1'b0; idxAWr = 1'b1; idxData = IDX_W'(4); tick();
    idxAWr = 1'b0; ctrlWr = 1'b1; ctrlData = 16'h0009; tick();
    ctrlWr = 1'b0;
    held = resultReg;
    repeat (4) tick();
    check("R8 busy start ignored finish", ctrlReg[2] == 1'b1, ctrlReg[2], 1);
    check("R8 busy start ignored result", resultReg == held, resultReg, held);
    // R8: start with mode bit 0 ignored
    wrCtrl(16'h0008);
    repeat (4) tick();
    check("R8 start without mode bit result", resultReg == held, resultReg, held);
    check("R8 start without mode bit finish", ctrlReg[2] == 1'b1, ctrlReg[2], 1);
    check("R8 mode bit follows write", ctrlReg[0] == 1'b0, ctrlReg[0], 0);
    wrCtrl(16'h0001);

    // R10: index write on the completing edge
    wrIdxA(2); wrIdxB(6);
    ctrlWr = 1'b1; ctrlData = 16'h0009; tick();
    ctrlWr = 1'b0; tick();
    idxAWr = 1'b1; idxData = IDX_W'(3); tick();
    idxAWr = 1'b0;
    check("R10 finish stays low", ctrlReg[2] == 1'b0, ctrlReg[2], 0);
    check("R10 result updated", int'(resultReg) == popRef(2, 6), resultReg, popRef(2, 6));

    // R9: soft reset cancels in-flight work and clears indexes
    wrIdxA(1); wrIdxB(1);
    ctrlWr = 1'b1; ctrlData = 16'h0009; tick();
    ctrlData = 16'h000B; tick();
    ctrlWr = 1'b0;
    r0 = ctrlReg;
    check("R9 ctrl cleared and reset bit reads 0", r0 == 16'h0, r0, 0);
    check("R9 result cleared", resultReg == '0, resultReg, 0);
    repeat (4) tick();
    check("R9 cancelled work never finishes", ctrlReg[2] == 1'b0, ctrlReg[2], 0);
    check("R9 result stays cleared", resultReg == '0, resultReg, 0);
    wrCtrl(16'h0001);
    goStart(popRef(0, 0));  // R1 R9 indexes back at 0
    dotReq(1, 1);           // R9 table kept: all-one row gives full count
    check("R9 all-one row count", int'(resultReg) == ROW_BITS, resultReg, ROW_BITS);

    repeat (2) tick();
    done = 1'b1;
    finishRun();
  end

endmodule